// File: doc/BRIEF.md
# Size-Scaled Indexed Address Generator

This block forms the byte address of a memory operand. It takes a word-granular reference address and can replace it with an indirect word that was fetched earlier. It can then add the contents of an index register, and it reports whether the resulting address suits the width of the operand. The index counts elements rather than bytes. The block shifts the index left by the operand size, so the same index value selects the same element number for byte, halfword, word or doubleword data, and software never pre-scales it.

The index registers sit in several register blocks. A block-select input picks the block used for the request, and a 3-bit index field picks one of the seven index-capable registers in that block. A simple load port fills those registers. Indexing is applied after indirection: when the indirect flag is set, the fetched indirect word becomes the reference and the index is added to it. Each request presented with `req_valid` produces one registered result in the following cycle.

Top module: `aga_top`

## Requirements
- R1: While reset is held, `out_valid` and `align_err` are 0, and every index register is cleared to zero.
- R2: A request sampled with `req_valid` high gives `out_valid` high in the next cycle, carrying that request's result. A cycle without a request gives `out_valid` low in the next cycle.
- R3: When `req_xsel` is 0, no index is added and `byte_addr` equals the reference word address times 4.
- R4: `req_size` encodes the operand size as 0 = byte, 1 = halfword, 2 = word and 3 = doubleword. The selected index value is shifted left by 0, 1, 2 or 3 bits respectively before it is added to the reference times 4.
- R5: When `req_indir` is 1, `req_iword` replaces `req_disp` as the reference, and the scaled index is added afterwards.
- R6: The index value comes from register `req_xsel` (1 to 7) of the block named by `req_blk`. Registers with the same number in other blocks do not affect the result.
- R7: A write with `wr_en` stores `wr_data` into register `wr_num` of block `wr_blk` only when `wr_num` is 1 to 7. A write to any other register number (0 or 8 to 15) changes no index register.
- R8: `align_err` is 1 with a result exactly when `byte_addr` is not a multiple of the operand size in bytes. For a byte operand it is therefore never 1.
- R9: The index is a two's-complement value. The sum wraps modulo 2 to the power of the byte-address width, so a negative index moves the address backward.
- R10: A write affects requests in later cycles. A request in the same cycle as a write to its index register uses the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Index register load strobe |
| wr_blk | input | 2 | Block written by the load port |
| wr_num | input | 4 | Register number written (only 1 to 7 are stored) |
| wr_data | input | 32 | Value loaded |
| req_valid | input | 1 | Address request strobe |
| req_disp | input | 20 | Reference word address |
| req_xsel | input | 3 | Index register number, 0 means no index |
| req_blk | input | 2 | Register block used by the request |
| req_indir | input | 1 | Use the indirect word as reference |
| req_iword | input | 20 | Fetched indirect word address |
| req_size | input | 2 | Operand size code |
| out_valid | output | 1 | Result valid |
| byte_addr | output | 22 | Effective byte address |
| align_err | output | 1 | Address misaligned for the operand size |

## Verification
Index registers hold state, so a wrong block decode or a write that lands on the wrong register stays hidden until some later request reads that register. The bench therefore writes distinct values into several blocks and then reads each one back through an address result. A write that should have been ignored shows up as a shifted address on the next request that uses register 1 of that block. A wrong scale or a wrong choice between indirect word and reference shows at the port one cycle after the request, so the scoreboard compares every result in the cycle it is due.

// File: rtl/aga_pkg.sv
package aga_pkg;

    // Operand size code; the numeric value is the log2 of the byte count.
    typedef enum logic [1:0] {
        OPSZ_BYTE  = 2'd0,
        OPSZ_HALF  = 2'd1,
        OPSZ_WORD  = 2'd2,
        OPSZ_DWORD = 2'd3
    } opsize_e;

    // Number of index-capable registers per block (numbers 1..7).
    localparam int unsigned XREG_N = 7;
    localparam int unsigned XSEL_W = 3;
    localparam int unsigned RNUM_W = 4;

    // Control portion of one address request.
    typedef struct packed {
        opsize_e            size;
        logic [XSEL_W-1:0]  xsel;
        logic               indir;
    } req_ctl_t;

    // Low-address-bit mask that must be zero for an aligned operand.
    function automatic logic [2:0] align_mask(input opsize_e sz);
        logic [2:0] m;
        unique case (sz)
            OPSZ_BYTE:  m = 3'b000;
            OPSZ_HALF:  m = 3'b001;
            OPSZ_WORD:  m = 3'b011;
            default:    m = 3'b111;
        endcase
        return m;
    endfunction

    // A register number names an index-capable register when it is 1..7.
    function automatic logic is_index_reg(input logic [RNUM_W-1:0] num);
        return (num[RNUM_W-1] == 1'b0) && (num[XSEL_W-1:0] != '0);
    endfunction

endpackage

// File: rtl/aga_idx_file.sv
module aga_idx_file
    import aga_pkg::*;
#(
    parameter int unsigned BLK_N = 4,
    parameter int unsigned IDX_W = 32,
    localparam int unsigned BLK_W = (BLK_N > 1) ? $clog2(BLK_N) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [BLK_W-1:0]     wr_blk,
    input  logic [RNUM_W-1:0]    wr_num,
    input  logic [IDX_W-1:0]     wr_data,
    input  logic [BLK_W-1:0]     rd_blk,
    input  logic [XSEL_W-1:0]    rd_sel,
    output logic [IDX_W-1:0]     rd_data
);

    logic [IDX_W-1:0] bank [BLK_N][XREG_N];
    logic             wr_ok;

    assign wr_ok = wr_en && is_index_reg(wr_num);

    for (genvar b = 0; b < BLK_N; b++) begin : g_blk
        for (genvar r = 0; r < XREG_N; r++) begin : g_reg
            logic hit;
            assign hit = wr_ok
                       && (wr_blk == BLK_W'(b))
                       && (wr_num[XSEL_W-1:0] == XSEL_W'(r + 1));
            always_ff @(posedge clk) begin
                if (rst) begin
                    bank[b][r] <= '0;
                end else if (hit) begin
                    bank[b][r] <= wr_data;
                end
            end
        end
    end

    // Read before write: a same-cycle write is seen from the next cycle on.
    always_comb begin
        rd_data = '0;
        for (int b = 0; b < BLK_N; b++) begin
            for (int r = 0; r < XREG_N; r++) begin
                if ((rd_blk == BLK_W'(b)) && (rd_sel == XSEL_W'(r + 1))) begin
                    rd_data = bank[b][r];
                end
            end
        end
    end

endmodule

// File: rtl/aga_scaler.sv
module aga_scaler
    import aga_pkg::*;
#(
    parameter int unsigned IDX_W  = 32,
    parameter int unsigned ADDR_W = 22
) (
    input  logic [IDX_W-1:0]  idx,
    input  opsize_e           size,
    output logic [ADDR_W-1:0] scaled
);

    localparam int unsigned WIDE_W = IDX_W + 3;

    logic [ADDR_W-1:0] cand [4];

    // One candidate per shift amount; the sum wraps, so truncation is modular.
    for (genvar s = 0; s < 4; s++) begin : g_shift
        logic [WIDE_W-1:0] wide;
        assign wide    = {3'b000, idx} << s;
        assign cand[s] = wide[ADDR_W-1:0];
    end

    always_comb begin
        unique case (size)
            OPSZ_BYTE:  scaled = cand[0];
            OPSZ_HALF:  scaled = cand[1];
            OPSZ_WORD:  scaled = cand[2];
            default:    scaled = cand[3];
        endcase
    end

endmodule

// File: rtl/aga_align.sv
module aga_align
    import aga_pkg::*;
#(
    parameter int unsigned ADDR_W = 22
) (
    input  logic [ADDR_W-1:0] addr,
    input  opsize_e           size,
    output logic              misaligned
);

    logic [2:0] low;

    assign low        = addr[2:0];
    assign misaligned = |(low & align_mask(size));

endmodule

// File: rtl/aga_top.sv
module aga_top
    import aga_pkg::*;
#(
    parameter int unsigned REF_W = 20,
    parameter int unsigned IDX_W = 32,
    parameter int unsigned BLK_N = 4,
    localparam int unsigned BLK_W  = (BLK_N > 1) ? $clog2(BLK_N) : 1,
    localparam int unsigned ADDR_W = REF_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BLK_W-1:0]  wr_blk,
    input  logic [3:0]        wr_num,
    input  logic [IDX_W-1:0]  wr_data,
    input  logic              req_valid,
    input  logic [REF_W-1:0]  req_disp,
    input  logic [2:0]        req_xsel,
    input  logic [BLK_W-1:0]  req_blk,
    input  logic              req_indir,
    input  logic [REF_W-1:0]  req_iword,
    input  logic [1:0]        req_size,
    output logic              out_valid,
    output logic [ADDR_W-1:0] byte_addr,
    output logic              align_err
);

    req_ctl_t          ctl;
    logic [IDX_W-1:0]  xval;
    logic [REF_W-1:0]  ref_word;
    logic [ADDR_W-1:0] ref_byte;
    logic [ADDR_W-1:0] xscaled;
    logic [ADDR_W-1:0] sum;
    logic              mis;

    assign ctl.size  = opsize_e'(req_size);
    assign ctl.xsel  = req_xsel;
    assign ctl.indir = req_indir;

    aga_idx_file #(
        .BLK_N (BLK_N),
        .IDX_W (IDX_W)
    ) u_xf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_blk  (wr_blk),
        .wr_num  (wr_num),
        .wr_data (wr_data),
        .rd_blk  (req_blk),
        .rd_sel  (ctl.xsel),
        .rd_data (xval)
    );

    // Indirection first, then the index is added (postindexing).
    assign ref_word = ctl.indir ? req_iword : req_disp;
    assign ref_byte = {ref_word, 2'b00};

    aga_scaler #(
        .IDX_W  (IDX_W),
        .ADDR_W (ADDR_W)
    ) u_sc (
        .idx    (xval),
        .size   (ctl.size),
        .scaled (xscaled)
    );

    assign sum = ref_byte + xscaled;

    aga_align #(
        .ADDR_W (ADDR_W)
    ) u_al (
        .addr       (sum),
        .size       (ctl.size),
        .misaligned (mis)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            byte_addr <= '0;
            align_err <= 1'b0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                byte_addr <= sum;
                align_err <= mis;
            end else begin
                align_err <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/aga_chk.sv
module aga_chk #(
    parameter int unsigned REF_W  = 20,
    parameter int unsigned ADDR_W = 22
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [REF_W-1:0]  req_disp,
    input logic [2:0]        req_xsel,
    input logic              req_indir,
    input logic [1:0]        req_size,
    input logic              out_valid,
    input logic [ADDR_W-1:0] byte_addr,
    input logic              align_err
);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);

    // R8
    err_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !align_err);

    // R8
    byte_never_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == 2'd0) |=> !align_err);

    // R8
    dword_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == 2'd3) |=> (align_err == (byte_addr[2:0] != 3'b000)));

    // R3
    no_index_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_xsel == 3'd0 && !req_indir)
        |=> (byte_addr == {$past(req_disp), 2'b00}));

endmodule

bind aga_top aga_chk #(
    .REF_W  (REF_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_disp  (req_disp),
    .req_xsel  (req_xsel),
    .req_indir (req_indir),
    .req_size  (req_size),
    .out_valid (out_valid),
    .byte_addr (byte_addr),
    .align_err (align_err)
);

// File: tb/sim_aga_top.sv
module sim_aga_top;

    localparam int REF_W  = 20;
    localparam int ADDR_W = 22;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_blk = '0;
    logic [3:0]        wr_num = '0;
    logic [31:0]       wr_data = '0;
    logic              req_valid = 1'b0;
    logic [REF_W-1:0]  req_disp = '0;
    logic [2:0]        req_xsel = '0;
    logic [1:0]        req_blk = '0;
    logic              req_indir = 1'b0;
    logic [REF_W-1:0]  req_iword = '0;
    logic [1:0]        req_size = '0;
    logic              out_valid;
    logic [ADDR_W-1:0] byte_addr;
    logic              align_err;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    logic [31:0]       mdl [4][16];
    logic [ADDR_W-1:0] q_addr [$];
    logic              q_err  [$];
    int                q_due  [$];
    string             q_tag  [$];

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    aga_top u0 (
        .clk (clk), .rst (rst),
        .wr_en (wr_en), .wr_blk (wr_blk), .wr_num (wr_num), .wr_data (wr_data),
        .req_valid (req_valid), .req_disp (req_disp), .req_xsel (req_xsel),
        .req_blk (req_blk), .req_indir (req_indir), .req_iword (req_iword),
        .req_size (req_size),
        .out_valid (out_valid), .byte_addr (byte_addr), .align_err (align_err)
    );

    // Driver: one cycle of stimulus; an optional write and an optional request.
    task automatic step(input bit we, input logic [1:0] wb, input logic [3:0] wn,
                        input logic [31:0] wd, input bit rv,
                        input logic [REF_W-1:0] disp, input logic [2:0] xs,
                        input logic [1:0] bk, input bit ind,
                        input logic [REF_W-1:0] iw, input logic [1:0] sz,
                        input string tag);
        logic [63:0] base, xv, total;
        logic [ADDR_W-1:0] ea;
        @(negedge clk);
        #1;
        wr_en = we; wr_blk = wb; wr_num = wn; wr_data = wd;
        req_valid = rv; req_disp = disp; req_xsel = xs; req_blk = bk;
        req_indir = ind; req_iword = iw; req_size = sz;
        if (rv) begin
            base  = {44'd0, (ind ? iw : disp)} << 2;
            xv    = (xs == 3'd0) ? 64'd0 : {32'd0, mdl[bk][xs]};
            total = base + (xv << sz);
            ea    = total[ADDR_W-1:0];
            q_addr.push_back(ea);
            q_err.push_back((ea & ((22'd1 << sz) - 22'd1)) != 0);
            q_due.push_back(cyc + 1);
            q_tag.push_back(tag);
        end
        if (we && wn >= 4'd1 && wn <= 4'd7) mdl[wb][wn] = wd;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
    endtask

    task automatic wr(input logic [1:0] b, input logic [3:0] n, input logic [31:0] d);
        step(1, b, n, d, 0, 0, 0, 0, 0, 0, 0, "wr");
    endtask

    task automatic rq(input logic [REF_W-1:0] disp, input logic [2:0] xs,
                      input logic [1:0] bk, input bit ind,
                      input logic [REF_W-1:0] iw, input logic [1:0] sz,
                      input string tag);
        step(0, 0, 0, 0, 1, disp, xs, bk, ind, iw, sz, tag);
    endtask

    // Monitor: compares results against the scoreboard in the cycle they are due.
    always @(negedge clk) begin
        if (!rst) begin
            if (q_due.size() != 0 && q_due[0] == cyc && !out_valid) begin
                tests++; fails++;
                $display("FAIL %s: out_valid=0 expected 1 (R2)", q_tag[0]);
                void'(q_addr.pop_front()); void'(q_err.pop_front());
                void'(q_due.pop_front());  void'(q_tag.pop_front());
            end else if (out_valid) begin
                if (q_due.size() == 0 || q_due[0] != cyc) begin
                    tests++; fails++;
                    $display("FAIL R2: out_valid=1 expected 0");
                end else begin
                    tests++;
                    if (byte_addr !== q_addr[0]) begin
                        fails++;
                        $display("FAIL %s: byte_addr=%h expected %h", q_tag[0], byte_addr, q_addr[0]);
                    end
                    tests++;
                    if (align_err !== q_err[0]) begin
                        fails++;
                        $display("FAIL %s: align_err=%0b expected %0b", q_tag[0], align_err, q_err[0]);
                    end
                    void'(q_addr.pop_front()); void'(q_err.pop_front());
                    void'(q_due.pop_front());  void'(q_tag.pop_front());
                end
            end
        end
    end

    initial begin
        for (int b = 0; b < 4; b++)
            for (int r = 0; r < 16; r++) mdl[b][r] = 32'd0;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        tests++;
        if (out_valid !== 1'b0 || align_err !== 1'b0) begin
            fails++;
            $display("FAIL R1: out_valid=%0b align_err=%0b expected 0 0", out_valid, align_err);
        end
        rq(20'h100, 3'd2, 2'd0, 0, 0, 2'd2, "R1 cleared index");
        rq(20'h100, 3'd7, 2'd3, 0, 0, 2'd3, "R1 cleared index");
        wr(2'd0, 4'd1, 32'd5);
        wr(2'd1, 4'd1, 32'd9);
        wr(2'd0, 4'd2, 32'hFFFF_FFFF);
        wr(2'd2, 4'd7, 32'h10);
        wr(2'd3, 4'd3, 32'd3);
        rq(20'h123, 3'd0, 2'd0, 0, 0, 2'd2, "R3 no index");
        rq(20'h040, 3'd1, 2'd0, 0, 0, 2'd0, "R4 byte scale");
        rq(20'h040, 3'd1, 2'd0, 0, 0, 2'd1, "R4 half scale");
        rq(20'h040, 3'd1, 2'd0, 0, 0, 2'd2, "R4 word scale");
        rq(20'h040, 3'd1, 2'd0, 0, 0, 2'd3, "R4 dword scale");
        idle();
        rq(20'h040, 3'd1, 2'd1, 0, 0, 2'd2, "R6 block select");
        rq(20'h050, 3'd7, 2'd2, 1, 20'h2000, 2'd1, "R5 postindex indirect");
        rq(20'h050, 3'd0, 2'd2, 1, 20'h2001, 2'd2, "R5 indirect no index");
        rq(20'h041, 3'd0, 2'd0, 0, 0, 2'd3, "R8 dword misaligned");
        rq(20'h041, 3'd1, 2'd0, 0, 0, 2'd1, "R8 half odd");
        rq(20'h041, 3'd1, 2'd0, 0, 0, 2'd0, "R8 byte never");
        rq(20'h010, 3'd2, 2'd0, 0, 0, 2'd2, "R9 negative index");
        rq(20'h000, 3'd2, 2'd0, 0, 0, 2'd0, "R9 wrap");
        wr(2'd0, 4'd9,  32'h777);
        wr(2'd0, 4'd0,  32'h55);
        wr(2'd0, 4'd15, 32'h1234);
        wr(2'd0, 4'd8,  32'h99);
        rq(20'h040, 3'd1, 2'd0, 0, 0, 2'd2, "R7 ignored writes");
        rq(20'h040, 3'd7, 2'd0, 0, 0, 2'd2, "R7 ignored writes");
        step(1, 2'd3, 4'd3, 32'h100, 1, 20'h008, 3'd3, 2'd3, 0, 0, 2'd0, "R10 same-cycle old value");
        rq(20'h008, 3'd3, 2'd3, 0, 0, 2'd0, "R10 new value");
        idle();
        idle();
        idle();
        tests++;
        if (q_due.size() != 0) begin
            fails++;
            $display("FAIL R2: %0d results outstanding expected 0", q_due.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule